// File: doc/BRIEF.md
# Oversampling Bus Bit Receiver

This block reads a single data bit from an open-drain two-wire serial bus while acting as the clock master. When a request arrives, it checks that the clock line is free (a target may be holding it low), pulls the clock low for a fixed half-period with the data line left undriven, then releases the clock. It waits again for any stretching to end and for a settle delay. After that it samples the synchronized data line a programmable number of times at a fixed spacing.

The number of high samples decides the result. Below a quarter of the window gives a 0. At three quarters or above gives a 1. Anything in between is reported as an ambiguous reception, so a short spike cannot flip the bit unnoticed. A stretch that outlasts a programmable limit aborts with a bus-lock code. A request made while the surrounding controller is not in an active transfer is refused at once. The clock line is always left released at the end of a bit, so another bit or a STOP can follow. Byte assembly, START/STOP generation and arbitration belong to the surrounding controller.

Top module: `i2c_bitrx_top`

## Requirements
- R1: After reset, scl_oe_o, sda_oe_o and done_o are all low.
- R2: A start_i pulse while bus_active_i is low produces done_o on the next cycle with err_o = 1 (invalid state), and scl_oe_o is never asserted for that request.
- R3: Before pulling the clock low, the block waits for the synchronized clock input to read high. If it stays low for longer than stretch_lim_i cycles, the block ends with err_o = 2 (bus lock) without ever asserting scl_oe_o.
- R4: During an accepted bit, scl_oe_o is asserted for exactly HALF_CYC consecutive cycles and then released.
- R5: After releasing the clock, the block waits for the clock input to read high before it samples. A stretch within stretch_lim_i still yields a good bit. A stretch beyond it ends with err_o = 2.
- R6: sda_oe_o is never asserted; the data line stays released for the target.
- R7: With win_len_i = N samples spaced GAP_CYC cycles apart, fewer than N/4 high samples gives err_o = 0 and bit_o = 0.
- R8: At least N/4 but fewer than 3N/4 high samples gives err_o = 3 (receive error) with bit_o = 0.
- R9: At least 3N/4 high samples gives err_o = 0 and bit_o = 1.
- R10: done_o is a one-cycle pulse, exactly one per request. A start_i pulse during a bit in progress is ignored.
- R11: Whenever done_o is high, scl_oe_o is low, so the clock is left released.
- R12: win_len_i = 0 is treated as a window of one sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to receive one bit |
| bus_active_i | input | 1 | High when the surrounding controller is in an active transfer |
| win_len_i | input | WIN_W | Number of data samples N |
| stretch_lim_i | input | TO_W | Maximum cycles to wait for clock release |
| scl_i | input | 1 | Clock pad input |
| sda_i | input | 1 | Data pad input |
| scl_oe_o | output | 1 | Drive clock pad low |
| sda_oe_o | output | 1 | Drive data pad low (never used here) |
| done_o | output | 1 | One-cycle completion pulse |
| bit_o | output | 1 | Received bit, valid with done_o |
| err_o | output | 2 | 0 ok, 1 invalid state, 2 bus lock, 3 receive error; valid with done_o |

## Verification
The hardest cases to reach are the decision-band edges, where the high-sample count has to land exactly on N/4 or 3N/4. Only the sample spacing is visible from the ports, not the sample instants. The bench therefore takes the cycle in which the clock pad rises after the low phase as its origin. It flips the data pad halfway between two expected sample instants, so the count comes out exact even with a cycle of uncertainty in the synchronizer path. Stretching is produced by a pad model that holds the clock low, either before the bit or right after the block releases the clock.

// File: rtl/i2c_bitrx_pkg.sv
package i2c_bitrx_pkg;

  typedef enum logic [1:0] {
    ERR_OK    = 2'd0,
    ERR_STATE = 2'd1,
    ERR_LOCK  = 2'd2,
    ERR_RECV  = 2'd3
  } rx_err_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_PRE,
    ST_LOW,
    ST_WAIT_POST,
    ST_SETTLE,
    ST_SAMPLE
  } rx_state_e;

endpackage

// File: rtl/i2c_bitrx_sync.sv
module i2c_bitrx_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  // idle bus reads high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= '1;
    else         stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '1;
      else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/i2c_bitrx_timer.sv
module i2c_bitrx_timer #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         dec_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (load_i)               cnt_q <= val_i;
    else if (dec_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/i2c_bitrx_vote.sv
module i2c_bitrx_vote #(
  parameter int WIN_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             smp_i,
  input  logic             sda_i,
  input  logic [WIN_W-1:0] win_i,
  output logic             full_o,
  output logic             one_o,
  output logic             amb_o
);

  localparam int CNT_W = WIN_W + 1;
  localparam int SUM_W = WIN_W + 3;

  logic [CNT_W-1:0] n_eff;
  logic [CNT_W-1:0] smp_q, ones_q;
  logic [SUM_W-1:0] ones_x4, n_x1, n_x3;

  assign n_eff = (win_i == '0) ? CNT_W'(1) : {1'b0, win_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_q  <= '0;
      ones_q <= '0;
    end else if (clr_i) begin
      smp_q  <= '0;
      ones_q <= '0;
    end else if (smp_i) begin
      smp_q  <= smp_q + 1'b1;
      ones_q <= ones_q + CNT_W'(sda_i);
    end
  end

  assign full_o  = (smp_q >= n_eff);
  assign ones_x4 = {ones_q, 2'b00};
  assign n_x1    = SUM_W'(n_eff);
  assign n_x3    = n_x1 + {n_x1[SUM_W-2:0], 1'b0};

  // bands: [0,N/4) -> 0, [N/4,3N/4) -> ambiguous, [3N/4,N] -> 1
  assign one_o = (ones_x4 >= n_x3);
  assign amb_o = (ones_x4 >= n_x1) && (ones_x4 < n_x3);

endmodule

// File: rtl/i2c_bitrx_top.sv
module i2c_bitrx_top
  import i2c_bitrx_pkg::*;
#(
  parameter int WIN_W       = 6,
  parameter int TO_W        = 12,
  parameter int HALF_CYC    = 8,
  parameter int SETTLE_CYC  = 4,
  parameter int GAP_CYC     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             bus_active_i,
  input  logic [WIN_W-1:0] win_len_i,
  input  logic [TO_W-1:0]  stretch_lim_i,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             scl_oe_o,
  output logic             sda_oe_o,
  output logic             done_o,
  output logic             bit_o,
  output logic [1:0]       err_o
);

  localparam int DLY_MAX = (HALF_CYC > SETTLE_CYC) ?
                           ((HALF_CYC > GAP_CYC) ? HALF_CYC : GAP_CYC) :
                           ((SETTLE_CYC > GAP_CYC) ? SETTLE_CYC : GAP_CYC);
  localparam int DLY_W   = $clog2(DLY_MAX + 1);
  localparam int TMR_W   = (TO_W > DLY_W) ? TO_W : DLY_W;

  localparam logic [TMR_W-1:0] HALF_LD   = TMR_W'(HALF_CYC - 1);
  localparam logic [TMR_W-1:0] SETTLE_LD = TMR_W'(SETTLE_CYC - 1);
  localparam logic [TMR_W-1:0] GAP_LD    = TMR_W'(GAP_CYC - 1);

  rx_state_e  state_q, state_d;
  logic [1:0] pad_s;
  logic       scl_s, sda_s;

  logic             tmr_load, tmr_dec, tmr_zero;
  logic [TMR_W-1:0] tmr_val;
  logic             smp, vote_clr, vote_full, vote_one, vote_amb;
  logic             fin, fin_bit;
  rx_err_e          fin_err;
  logic             done_q, bit_q;
  logic [1:0]       err_q;

  i2c_bitrx_sync #(
    .WIDTH  (2),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({scl_i, sda_i}),
    .q_o    (pad_s)
  );

  assign scl_s = pad_s[1];
  assign sda_s = pad_s[0];

  i2c_bitrx_timer #(
    .W (TMR_W)
  ) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .dec_i  (tmr_dec),
    .zero_o (tmr_zero)
  );

  i2c_bitrx_vote #(
    .WIN_W (WIN_W)
  ) u_vote (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (vote_clr),
    .smp_i  (smp),
    .sda_i  (sda_s),
    .win_i  (win_len_i),
    .full_o (vote_full),
    .one_o  (vote_one),
    .amb_o  (vote_amb)
  );

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    tmr_dec  = 1'b0;
    smp      = 1'b0;
    vote_clr = 1'b0;
    fin      = 1'b0;
    fin_err  = ERR_OK;
    fin_bit  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        vote_clr = 1'b1;
        if (start_i) begin
          if (!bus_active_i) begin
            fin     = 1'b1;
            fin_err = ERR_STATE;
          end else begin
            state_d  = ST_WAIT_PRE;
            tmr_load = 1'b1;
            tmr_val  = TMR_W'(stretch_lim_i);
          end
        end
      end
      ST_WAIT_PRE: begin
        if (scl_s) begin
          state_d  = ST_LOW;
          tmr_load = 1'b1;
          tmr_val  = HALF_LD;
        end else if (tmr_zero) begin
          state_d = ST_IDLE;
          fin     = 1'b1;
          fin_err = ERR_LOCK;
        end else begin
          tmr_dec = 1'b1;
        end
      end
      ST_LOW: begin
        if (tmr_zero) begin
          state_d  = ST_WAIT_POST;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(stretch_lim_i);
        end else begin
          tmr_dec = 1'b1;
        end
      end
      ST_WAIT_POST: begin
        if (scl_s) begin
          state_d  = ST_SETTLE;
          tmr_load = 1'b1;
          tmr_val  = SETTLE_LD;
        end else if (tmr_zero) begin
          state_d = ST_IDLE;
          fin     = 1'b1;
          fin_err = ERR_LOCK;
        end else begin
          tmr_dec = 1'b1;
        end
      end
      ST_SETTLE: begin
        if (tmr_zero) begin
          state_d  = ST_SAMPLE;
          vote_clr = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = '0;
        end else begin
          tmr_dec = 1'b1;
        end
      end
      ST_SAMPLE: begin
        if (vote_full) begin
          state_d = ST_IDLE;
          fin     = 1'b1;
          fin_err = vote_amb ? ERR_RECV : ERR_OK;
          fin_bit = vote_one;
        end else if (tmr_zero) begin
          smp      = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = GAP_LD;
        end else begin
          tmr_dec = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      bit_q   <= 1'b0;
      err_q   <= ERR_OK;
    end else begin
      state_q <= state_d;
      done_q  <= fin;
      if (fin) begin
        bit_q <= fin_bit;
        err_q <= fin_err;
      end
    end
  end

  assign scl_oe_o = (state_q == ST_LOW);
  assign sda_oe_o = 1'b0;
  assign done_o   = done_q;
  assign bit_o    = bit_q;
  assign err_o    = err_q;

endmodule

// File: rtl/i2c_bitrx_chk.sv
module i2c_bitrx_chk #(
  parameter int HALF_CYC = 8
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       bus_active_i,
  input logic       idle_i,
  input logic       scl_oe_o,
  input logic       done_o,
  input logic       bit_o,
  input logic [1:0] err_o
);

  int unsigned oe_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       oe_run_q <= 0;
    else if (scl_oe_o) oe_run_q <= oe_run_q + 1;
    else               oe_run_q <= 0;
  end

  // R2
  refuse_inactive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_i && start_i && !bus_active_i) |=> (done_o && err_o == 2'd1));

  // R4
  low_phase_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(scl_oe_o) |-> (oe_run_q == HALF_CYC));

  // R8
  err_clears_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o != 2'd0) |-> !bit_o);

  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R11
  clock_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !scl_oe_o);

endmodule

bind i2c_bitrx_top i2c_bitrx_chk #(
  .HALF_CYC (HALF_CYC)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .bus_active_i (bus_active_i),
  .idle_i       (state_q == i2c_bitrx_pkg::ST_IDLE),
  .scl_oe_o     (scl_oe_o),
  .done_o       (done_o),
  .bit_o        (bit_o),
  .err_o        (err_o)
);

// File: tb/test_i2c_bitrx_top.sv
module test_i2c_bitrx_top;

  localparam int CLK_PERIOD = 10;
  localparam int WIN_W      = 6;
  localparam int TO_W       = 12;
  localparam int HALF_CYC   = 8;
  localparam int SETTLE_CYC = 4;
  localparam int GAP_CYC    = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic             bus_active_i = 1'b1;
  logic [WIN_W-1:0] win_len_i = '0;
  logic [TO_W-1:0]  stretch_lim_i = '0;
  logic             tgt_scl_low = 1'b0;
  logic             tgt_sda_low = 1'b0;
  logic             scl_oe_o, sda_oe_o, done_o, bit_o;
  logic [1:0]       err_o;
  logic             scl_pad, sda_pad;

  int n_tests = 0;
  int n_fail  = 0;
  int done_cnt = 0;
  int oe_cnt   = 0;
  int sda_oe_cnt = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign scl_pad = !(scl_oe_o || tgt_scl_low);
  assign sda_pad = !(sda_oe_o || tgt_sda_low);

  i2c_bitrx_top #(
    .WIN_W      (WIN_W),
    .TO_W       (TO_W),
    .HALF_CYC   (HALF_CYC),
    .SETTLE_CYC (SETTLE_CYC),
    .GAP_CYC    (GAP_CYC)
  ) i_i2c_bitrx_top (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .start_i       (start_i),
    .bus_active_i  (bus_active_i),
    .win_len_i     (win_len_i),
    .stretch_lim_i (stretch_lim_i),
    .scl_i         (scl_pad),
    .sda_i         (sda_pad),
    .scl_oe_o      (scl_oe_o),
    .sda_oe_o      (sda_oe_o),
    .done_o        (done_o),
    .bit_o         (bit_o),
    .err_o         (err_o)
  );

  always @(negedge clk) begin
    if (done_o)   done_cnt++;
    if (scl_oe_o) oe_cnt++;
    if (sda_oe_o) sda_oe_cnt++;
  end

  task automatic chk(input string tag, input int got, input int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic issue(output int err, output int b, output int lat);
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    lat = 0;
    while (!done_o && lat < 3000) begin
      @(negedge clk);
      lat++;
    end
    chk("R10 done seen", int'(done_o), 1);
    err = int'(err_o);
    b   = int'(bit_o);
    chk("R11 clock released at done", int'(scl_oe_o), 0);
  endtask

  // origin: first negedge with clock released after the low phase
  task automatic wait_release();
    int k = 0;
    while (!scl_oe_o && k < 3000) begin @(negedge clk); k++; end
    while (scl_oe_o && k < 3000)  begin @(negedge clk); k++; end
  endtask

  // data high for exactly hi samples, then low
  task automatic bit_case(input string tag, input int win, input int hi,
                          input int exp_err, input int exp_bit);
    int err, b, lat, oe0;
    win_len_i = WIN_W'(win);
    stretch_lim_i = TO_W'(40);
    tgt_sda_low = 1'b0;
    oe0 = oe_cnt;
    fork
      issue(err, b, lat);
      begin
        wait_release();
        repeat (1 + SETTLE_CYC + hi * GAP_CYC - GAP_CYC / 2) @(negedge clk);
        tgt_sda_low = 1'b1;
      end
    join
    tgt_sda_low = 1'b0;
    chk({tag, " err"}, err, exp_err);
    chk({tag, " bit"}, b, exp_bit);
    chk("R4 low phase length", oe_cnt - oe0, HALF_CYC);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 scl_oe after reset", int'(scl_oe_o), 0);
    chk("R1 sda_oe after reset", int'(sda_oe_o), 0);
    chk("R1 done after reset", int'(done_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_inactive();
    int err, b, lat, oe0;
    bus_active_i = 1'b0;
    oe0 = oe_cnt;
    issue(err, b, lat);
    chk("R2 invalid state code", err, 1);
    chk("R2 immediate done", lat, 0);
    repeat (10) @(negedge clk);
    chk("R2 no clock activity", oe_cnt - oe0, 0);
    bus_active_i = 1'b1;
  endtask

  task automatic t_pre_stretch_ok();
    int err, b, lat, oe0, oe_mid;
    win_len_i = WIN_W'(8);
    stretch_lim_i = TO_W'(50);
    tgt_scl_low = 1'b1;
    oe0 = oe_cnt;
    oe_mid = 0;
    fork
      issue(err, b, lat);
      begin
        repeat (20) @(negedge clk);
        oe_mid = oe_cnt - oe0;
        tgt_scl_low = 1'b0;
      end
    join
    chk("R3 no drive while stretched", oe_mid, 0);
    chk("R3 stretch tolerated err", err, 0);
    chk("R3 stretch tolerated bit", b, 1);
  endtask

  task automatic t_pre_lock();
    int err, b, lat, oe0;
    stretch_lim_i = TO_W'(10);
    tgt_scl_low = 1'b1;
    oe0 = oe_cnt;
    issue(err, b, lat);
    tgt_scl_low = 1'b0;
    chk("R3 bus lock code", err, 2);
    chk("R3 no clock before lock", oe_cnt - oe0, 0);
    repeat (5) @(negedge clk);
  endtask

  task automatic t_post_stretch(input int lim, input int exp_err, input int exp_bit);
    int err, b, lat;
    win_len_i = WIN_W'(8);
    stretch_lim_i = TO_W'(lim);
    fork
      issue(err, b, lat);
      begin
        int k = 0;
        while (!scl_oe_o && k < 3000) begin @(negedge clk); k++; end
        tgt_scl_low = 1'b1;
        while (scl_oe_o && k < 3000) begin @(negedge clk); k++; end
        repeat (25) @(negedge clk);
        tgt_scl_low = 1'b0;
      end
    join
    chk("R5 post-release stretch err", err, exp_err);
    chk("R5 post-release stretch bit", b, exp_bit);
    repeat (5) @(negedge clk);
  endtask

  task automatic t_busy_ignore();
    int err, b, lat, d0, oe0;
    win_len_i = WIN_W'(4);
    stretch_lim_i = TO_W'(40);
    d0 = done_cnt;
    oe0 = oe_cnt;
    fork
      issue(err, b, lat);
      begin
        repeat (6) @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
      end
    join
    repeat (60) @(negedge clk);
    chk("R10 single done per request", done_cnt - d0, 1);
    chk("R10 no second low phase", oe_cnt - oe0, HALF_CYC);
    chk("R10 bit unaffected", b, 1);
  endtask

  initial begin
    t_reset();
    t_inactive();
    // R7: below N/4
    bit_case("R7 N8 one high", 8, 1, 0, 0);
    bit_case("R7 N8 all low", 8, 0, 0, 0);
    bit_case("R7 N16 three high", 16, 3, 0, 0);
    // R8: ambiguous band edges
    bit_case("R8 N8 at quarter", 8, 2, 3, 0);
    bit_case("R8 N8 five high", 8, 5, 3, 0);
    bit_case("R8 N16 eleven high", 16, 11, 3, 0);
    // R9: upper band
    bit_case("R9 N8 at three quarters", 8, 6, 0, 1);
    bit_case("R9 N8 all high", 8, 8, 0, 1);
    bit_case("R9 N16 twelve high", 16, 12, 0, 1);
    // R12: zero window acts as one sample
    bit_case("R12 win0 high", 0, 1, 0, 1);
    bit_case("R12 win0 low", 0, 0, 0, 0);
    t_pre_stretch_ok();
    t_pre_lock();
    t_post_stretch(50, 0, 1);
    t_post_stretch(10, 2, 0);
    t_busy_ignore();
    chk("R6 data line never driven", sda_oe_cnt, 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule